// File: doc/BRIEF.md
# Bus Interface Control and Interrupt Register

This block is the control register of a host-bus interface unit. Software writes it through a small address/data port. From it the block drives the reset line of the processor core, including that core's instruction cache. Set and release of that reset use two separate write-one bits. The block also gates the pixel-write requests of a coprocessor onto the bus. It forces bus mastering on when the device acts as the bus host, and it picks the PCI read command that the DMA engine issues.

The bus engines report six kinds of event with single-cycle pulses. Each event latches a sticky status bit, and software clears a status bit by writing one to it. A single interrupt line is raised while any latched event has its enable bit set. The PCI protocol engines and the reset domains of the caches and peripherals sit outside this block.

Top module: `busif_ctrl`

## Requirements
- R1: After synchronous reset, `core_rst` is 1. The coprocessor enable, host mode, read-multiple disable, all interrupt enables and all status bits are 0, and `irq` is 0.
- R2: A write to the control address (0) with data bit 0 set drives `core_rst` to 1 from the next cycle. A control write with bit 0 clear leaves `core_rst` unchanged unless R3 applies. `core_rst` changes on no other input.
- R3: A control write with data bit 1 set and bit 0 clear releases `core_rst` to 0 from the next cycle. A write with both bits set leaves the core in reset.
- R4: Asserting or releasing `core_rst` leaves every other control field and every status bit unchanged.
- R5: `cop_grant` equals `cop_req` ANDed with the coprocessor enable. The coprocessor enable is control bit 2.
- R6: `bm_en` equals `bm_en_cfg` ORed with host mode, which is control bit 3.
- R7: `rdcmd_cpu` is always 4'b0110 (memory read). `rdcmd_dma` is 4'b1100 (memory read multiple) while control bit 4 (read-multiple disable) is 0, and 4'b0110 while it is 1.
- R8: A pulse on `ev_pulse[i]` sets status bit i from the next cycle, and the bit stays set until software clears it. The indices are: 0 config cycle done, 1 I/O cycle done, 2 DMA cycle done, 3 PCI-to-DRAM write done, 4 second config/I/O request while one is pending, 5 second DMA request while one is pending.
- R9: A write to the status address (1) clears every status bit whose data bit is 1. An event arriving in the same cycle keeps its bit set.
- R10: `irq` is 1 exactly when some status bit i is set together with interrupt enable i. The enables are control bits 8 to 13, in the event order of R8.
- R11: Reading address 0 returns `core_rst` in bit 0, the control fields in bits 2 to 4 and the enables in bits 8 to 13, with zeros elsewhere. Address 1 returns the status in bits 0 to 5. Other addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| ev_pulse | input | 6 | Single-cycle event pulses from the bus engines |
| cop_req | input | 1 | Coprocessor pixel-write request |
| cop_grant | output | 1 | Request passed to the bus interface |
| bm_en_cfg | input | 1 | Bus-master enable from configuration space |
| bm_en | output | 1 | Effective bus-master enable |
| rdcmd_dma | output | 4 | PCI read command for DMA reads |
| rdcmd_cpu | output | 4 | PCI read command for processor reads |
| core_rst | output | 1 | Reset to the processor core and instruction cache |
| irq | output | 1 | Interrupt request |
| irq_status | output | 6 | Sticky event status |

## Verification
The bench builds the block with its default parameters: a 32-bit data port and a 2-bit address. The 2-bit address lets stimulus reach the two unused addresses as well as the two live ones. Random writes and event pulses, run for several hundred cycles, cover every pairing of set and clear bits in the core-reset control. They also make events collide with status clears in the same cycle and sweep the enable patterns against the latched status.

// File: rtl/busif_ctrl_pkg.sv
package busif_ctrl_pkg;

    localparam int NUM_EV = 6;

    // control word bit positions
    localparam int B_HOLD_SET = 0;
    localparam int B_HOLD_CLR = 1;
    localparam int B_COP_EN   = 2;
    localparam int B_HOST     = 3;
    localparam int B_RDMUL_OFF = 4;
    localparam int B_IEN_LO   = 8;
    localparam int CTRL_TOP   = B_IEN_LO + NUM_EV - 1;

    // register addresses
    localparam int A_CTRL   = 0;
    localparam int A_STATUS = 1;

    typedef enum logic [3:0] {
        CMD_MEMRD    = 4'b0110,
        CMD_MEMRDMUL = 4'b1100
    } pci_rdcmd_e;

    typedef struct packed {
        logic                cop_en;
        logic                host;
        logic                rdmul_off;
        logic [NUM_EV-1:0]   ien;
    } ctrl_t;

    function automatic logic irq_of(input logic [NUM_EV-1:0] st,
                                    input logic [NUM_EV-1:0] en);
        return |(st & en);
    endfunction

    function automatic pci_rdcmd_e dma_cmd(input logic rdmul_off);
        return rdmul_off ? CMD_MEMRD : CMD_MEMRDMUL;
    endfunction

endpackage

// File: rtl/busif_ctrl_regs.sv
module busif_ctrl_regs
    import busif_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctrl_wr,
    input  logic [CTRL_TOP:0]   wdata,
    output ctrl_t               ctrl,
    output logic                core_rst
);

    always_ff @(posedge clk) begin
        if (rst) begin
            core_rst <= 1'b1;
            ctrl     <= '0;
        end else if (ctrl_wr) begin
            if (wdata[B_HOLD_SET])
                core_rst <= 1'b1;
            else if (wdata[B_HOLD_CLR])
                core_rst <= 1'b0;
            ctrl.cop_en    <= wdata[B_COP_EN];
            ctrl.host      <= wdata[B_HOST];
            ctrl.rdmul_off <= wdata[B_RDMUL_OFF];
            ctrl.ien       <= wdata[CTRL_TOP:B_IEN_LO];
        end
    end

    assert_set_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata[B_HOLD_SET]) |=> core_rst);

    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(core_rst));

    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata[B_HOLD_CLR] && !wdata[B_HOLD_SET]) |=> !core_rst);

endmodule

// File: rtl/busif_cmd_sel.sv
module busif_cmd_sel
    import busif_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctrl_t      ctrl,
    input  logic       cop_req,
    input  logic       bm_en_cfg,
    output logic       cop_grant,
    output logic       bm_en,
    output logic [3:0] rdcmd_dma,
    output logic [3:0] rdcmd_cpu
);

    always_comb begin
        cop_grant = cop_req & ctrl.cop_en;
        bm_en     = bm_en_cfg | ctrl.host;
        rdcmd_dma = dma_cmd(ctrl.rdmul_off);
        rdcmd_cpu = CMD_MEMRD;
    end

    assert_grant_gated_R5: assert property (@(posedge clk) disable iff (rst)
        cop_grant |-> (cop_req && ctrl.cop_en));

    assert_host_master_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl.host |-> bm_en);

    assert_dma_plain_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.rdmul_off |-> (rdcmd_dma == rdcmd_cpu));

endmodule

// File: rtl/busif_irq_unit.sv
module busif_irq_unit
    import busif_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev,
    input  logic [NUM_EV-1:0] clr,
    input  logic [NUM_EV-1:0] ien,
    output logic [NUM_EV-1:0] status,
    output logic              irq
);

    generate
        for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
            always_ff @(posedge clk) begin
                if (rst)
                    status[i] <= 1'b0;
                else if (ev[i])
                    status[i] <= 1'b1;
                else if (clr[i])
                    status[i] <= 1'b0;
            end

            assert_sticky_set_R8: assert property (@(posedge clk) disable iff (rst)
                ev[i] |=> status[i]);

            assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && !ev[i]) |=> !status[i]);
        end
    endgenerate

    assign irq = irq_of(status, ien);

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(|ev) || !$stable(ien)));

endmodule

// File: rtl/busif_ctrl.sv
module busif_ctrl
    import busif_ctrl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_EV-1:0] ev_pulse,
    input  logic              cop_req,
    output logic              cop_grant,
    input  logic              bm_en_cfg,
    output logic              bm_en,
    output logic [3:0]        rdcmd_dma,
    output logic [3:0]        rdcmd_cpu,
    output logic              core_rst,
    output logic              irq,
    output logic [NUM_EV-1:0] irq_status
);

    localparam int UNUSED_W = DATA_W - CTRL_TOP - 1;

    ctrl_t             ctrl;
    logic              ctrl_wr;
    logic [NUM_EV-1:0] st_clr;
    logic              unused_hi;

    assign ctrl_wr   = wr_en && (addr == ADDR_W'(A_CTRL));
    assign st_clr    = (wr_en && (addr == ADDR_W'(A_STATUS))) ? wr_data[NUM_EV-1:0] : '0;
    assign unused_hi = ^wr_data[DATA_W-1:DATA_W-UNUSED_W];

    busif_ctrl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .wdata    (wr_data[CTRL_TOP:0]),
        .ctrl     (ctrl),
        .core_rst (core_rst)
    );

    busif_cmd_sel u_cmd (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .cop_req   (cop_req),
        .bm_en_cfg (bm_en_cfg),
        .cop_grant (cop_grant),
        .bm_en     (bm_en),
        .rdcmd_dma (rdcmd_dma),
        .rdcmd_cpu (rdcmd_cpu)
    );

    busif_irq_unit u_irq (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev_pulse),
        .clr    (st_clr),
        .ien    (ctrl.ien),
        .status (irq_status),
        .irq    (irq)
    );

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(A_CTRL)) begin
            rd_data[B_HOLD_SET]          = core_rst;
            rd_data[B_COP_EN]            = ctrl.cop_en;
            rd_data[B_HOST]              = ctrl.host;
            rd_data[B_RDMUL_OFF]         = ctrl.rdmul_off;
            rd_data[CTRL_TOP:B_IEN_LO]   = ctrl.ien;
        end else if (addr == ADDR_W'(A_STATUS)) begin
            rd_data[NUM_EV-1:0] = irq_status;
        end
    end

endmodule

// File: tb/busif_ctrl_bench.sv
module busif_ctrl_bench;

    localparam int DW = 32;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [5:0]    ev_pulse = '0;
    logic          cop_req = 1'b0;
    logic          cop_grant;
    logic          bm_en_cfg = 1'b0;
    logic          bm_en;
    logic [3:0]    rdcmd_dma, rdcmd_cpu;
    logic          core_rst, irq;
    logic [5:0]    irq_status;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_rst, m_cop, m_host, m_rmd, m_en, m_st;

    busif_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u_busif_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .ev_pulse(ev_pulse), .cop_req(cop_req),
        .cop_grant(cop_grant), .bm_en_cfg(bm_en_cfg), .bm_en(bm_en),
        .rdcmd_dma(rdcmd_dma), .rdcmd_cpu(rdcmd_cpu), .core_rst(core_rst),
        .irq(irq), .irq_status(irq_status)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_rst = 1; m_cop = 0; m_host = 0; m_rmd = 0; m_en = 0; m_st = 0;
        end else begin
            int clrmask;
            clrmask = (wr_en && addr == 1) ? int'(wr_data[5:0]) : 0;
            if (wr_en && addr == 0) begin
                if (wr_data[0]) m_rst = 1;
                else if (wr_data[1]) m_rst = 0;
                m_cop  = wr_data[2];
                m_host = wr_data[3];
                m_rmd  = wr_data[4];
                m_en   = int'(wr_data[13:8]);
            end
            m_st = (m_st & ~clrmask) | int'(ev_pulse);
        end
    endtask

    task automatic compare_all();
        int exp_rd;
        chk("R2/R3 core_rst", core_rst, m_rst);
        chk("R5 cop_grant", cop_grant, cop_req & m_cop);
        chk("R6 bm_en", bm_en, bm_en_cfg | m_host);
        chk("R7 rdcmd_cpu", rdcmd_cpu, 4'b0110);
        chk("R7 rdcmd_dma", rdcmd_dma, m_rmd ? 4'b0110 : 4'b1100);
        chk("R8/R9 status", irq_status, m_st);
        chk("R10 irq", irq, (m_st & m_en) != 0);
        if (addr == 0)      exp_rd = m_rst | (m_cop << 2) | (m_host << 3) | (m_rmd << 4) | (m_en << 8);
        else if (addr == 1) exp_rd = m_st;
        else                exp_rd = 0;
        chk("R11 rd_data", rd_data, exp_rd);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #5;
        compare_all();
    endtask

    task automatic idle();
        wr_en = 0; ev_pulse = '0;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; addr = AW'(a); wr_data = DW'(d);
        step();
        idle();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        // R1: reset state
        chk("R1 core_rst", core_rst, 1);
        chk("R1 irq", irq, 0);
        chk("R1 status", irq_status, 0);
        addr = 0; #1; chk("R1 ctrl readback", rd_data, 1);

        // R3: release, then both bits together keep reset
        wr(0, 32'h2);
        chk("R3 released", core_rst, 0);
        wr(0, 32'h0);
        chk("R2 zero write no effect", core_rst, 0);
        // enable fields and events, then set reset and confirm state kept (R4)
        wr(0, 32'h3F1C | 32'h2);
        ev_pulse = 6'b100101; step(); idle();
        wr(0, 32'h3F1C | 32'h1);
        chk("R2 set asserts", core_rst, 1);
        chk("R4 status kept", irq_status, 6'b100101);
        addr = 0; #1; chk("R4 fields kept", rd_data, 32'h3F1D);
        wr(0, 32'h3F1C | 32'h3);
        chk("R3 both bits stay in reset", core_rst, 1);

        // R9: clear colliding with event
        ev_pulse = 6'b000100; wr_en = 1; addr = 1; wr_data = 32'h3F;
        step(); idle();
        chk("R9 event wins over clear", irq_status, 6'b000100);

        // R7 / R5 / R6 directed
        cop_req = 1; bm_en_cfg = 0;
        wr(0, 32'h10);
        chk("R7 dma plain read", rdcmd_dma, 4'b0110);
        chk("R5 grant refused", cop_grant, 0);
        chk("R6 bm from cfg only", bm_en, 0);

        // random traffic
        for (int n = 0; n < 600; n++) begin
            wr_en     = ($urandom % 3) == 0;
            addr      = AW'($urandom);
            wr_data   = $urandom;
            ev_pulse  = 6'($urandom) & 6'($urandom);
            cop_req   = 1'($urandom);
            bm_en_cfg = 1'($urandom);
            step();
        end
        idle();
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule